// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This controller switches the gateable power domains of a chip off and on, one at a time. Each domain owns one bit in four control vectors: clock enable, isolation enable, reset release and power-down request. A command names a domain index and a direction. The sequencer then walks that domain's bits through a fixed series of steps. It holds a settle gap between steps, and it polls a per-domain acknowledge from the power switch. That acknowledge first passes through a two-flop synchronizer.

To power a domain down, the sequencer gates its clock, isolates its outputs, holds it in reset and asks the switch to cut power. To power it up, it runs the same steps in reverse, and the switch acknowledge must drop before any other step begins. Each direction has its own poll limit. When the switch does not respond in time, the command ends with an error, the bits stay where they stopped, and a sticky per-domain error flag is set. A read port exposes the four control vectors and the synchronized acknowledge as 32-bit words at fixed byte addresses.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, every domain is powered on: all bits of clk_en and rst_rel are 1, all bits of iso_en, pwr_dn and err_flag are 0, and req_ready is 1.
- R2: A power-off command (req_on=0) clears the domain's clk_en bit on the accepting edge. Exactly SETTLE_CYC cycles later it sets iso_en. SETTLE_CYC cycles after that it clears rst_rel, and SETTLE_CYC cycles after that it sets pwr_dn. SETTLE_CYC is ceil(CLK_MHZ*SETTLE_NS/1000).
- R3: After pwr_dn is set, the power-off command ends with a one-cycle done pulse and done_err=0 once the synchronized acknowledge bit of the domain reads 1.
- R4: A power-on command (req_on=1) clears pwr_dn on the accepting edge and waits until the synchronized acknowledge reads 0. It then sets rst_rel, clears iso_en SETTLE_CYC cycles later, sets clk_en SETTLE_CYC cycles after that, and raises done SETTLE_CYC cycles after that.
- R5: If the acknowledge is still 0 after OFF_POLLS polls of POLL_CYC cycles each, done rises with done_err=1 exactly OFF_POLLS*POLL_CYC cycles after pwr_dn was set. The domain's err_flag bit is set, and the control bits keep the values of the failing step.
- R6: If the acknowledge is still 1 after ON_POLLS polls on power-on, done rises with done_err=1 exactly ON_POLLS*POLL_CYC cycles after the command is accepted, and the domain's err_flag bit is set.
- R7: A command changes only the selected domain's bit in each control vector.
- R8: A command for an index outside GATE_LO..GATE_HI (2..5 by default) gives done with done_err=1 in the cycle after acceptance and leaves every control bit and err_flag unchanged.
- R9: While a command runs, req_ready is 0 and a request is not taken.
- R10: rd_data returns clk_en at byte address 0x18, rst_rel at 0x1C, iso_en at 0x20, pwr_dn at 0x24 and the synchronized acknowledge at 0x28, with bit i belonging to domain i. Every other address reads 0.
- R11: Accepting a command for a gateable domain clears that domain's err_flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_dom | input | IDX_W | Domain index of the command |
| req_on | input | 1 | 1 powers the domain on, 0 powers it off |
| req_ready | output | 1 | Sequencer idle, command may be taken |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion with error, valid with done |
| ack_in | input | NUM_DOM | Asynchronous power-switch acknowledge per domain |
| clk_en | output | NUM_DOM | Clock enable per domain |
| iso_en | output | NUM_DOM | Isolation enable per domain |
| rst_rel | output | NUM_DOM | Reset release per domain, 0 holds the domain in reset |
| pwr_dn | output | NUM_DOM | Power-down request per domain |
| err_flag | output | NUM_DOM | Sticky timeout flag per domain |
| rd_addr | input | ADDR_W | Status window byte address |
| rd_data | output | DATA_W | Status window read data |

## Verification
The hardest states to reach are the two timeouts. A working switch always answers, so the bench's acknowledge model can pin any domain's acknowledge to a fixed level. A domain pinned at 0 during power-off runs out of polls with power-down requested. A domain that is already on, pinned at 1, fails its power-on wait. The bench then recovers each failed domain with a later command, which must clear the sticky flag. The bench counts cycles from the edge where each bit changes, so the exact settle and timeout windows are checked and not only the final state.

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter int NUM_DOM   = 7,
  parameter int IDX_W     = 3,
  parameter int GATE_LO   = 2,
  parameter int GATE_HI   = 5,
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_NS = 5000,
  parameter int POLL_CYC  = 4,
  parameter int OFF_POLLS = 1000,
  parameter int ON_POLLS  = 10000,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_dom,
  input  logic               req_on,
  output logic               req_ready,
  output logic               done,
  output logic               done_err,
  input  logic [NUM_DOM-1:0] ack_in,
  output logic [NUM_DOM-1:0] clk_en,
  output logic [NUM_DOM-1:0] iso_en,
  output logic [NUM_DOM-1:0] rst_rel,
  output logic [NUM_DOM-1:0] pwr_dn,
  output logic [NUM_DOM-1:0] err_flag,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int SETTLE_RAW = (CLK_MHZ * SETTLE_NS + 999) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int CNT_MAX    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int POLL_MAX   = (OFF_POLLS > ON_POLLS) ? OFF_POLLS : ON_POLLS;
  localparam int PL_W       = $clog2(POLL_MAX + 1);

  localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_ISO = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_PWR = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(8'h28);

  typedef enum logic [3:0] {
    S_IDLE, S_OFF_ISO, S_OFF_RST, S_OFF_PD, S_OFF_ACK,
    S_ON_ACK, S_ON_ISO, S_ON_CLK, S_ON_END, S_DONE
  } state_t;

  state_t st;
  logic [IDX_W-1:0]   dom_q;
  logic               err_q;
  logic [CNT_W-1:0]   cnt;
  logic [PL_W-1:0]    polls;
  logic [NUM_DOM-1:0] ack_s1, ack_s2;
  logic [NUM_DOM-1:0] clk_q, iso_q, rst_q, pd_q, errf_q;

  wire [NUM_DOM-1:0] sel      = NUM_DOM'(1) << dom_q;
  wire [NUM_DOM-1:0] req_sel  = NUM_DOM'(1) << req_dom;
  wire               req_ok   = (int'(req_dom) >= GATE_LO) && (int'(req_dom) <= GATE_HI) &&
                                (int'(req_dom) < NUM_DOM);
  wire               settle_end = (cnt == CNT_W'(SETTLE_CYC - 1));
  wire               poll_tick  = (cnt == CNT_W'(POLL_CYC - 1));
  wire               ack_now    = |(ack_s2 & sel);

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign done_err  = done & err_q;
  assign clk_en    = clk_q;
  assign iso_en    = iso_q;
  assign rst_rel   = rst_q;
  assign pwr_dn    = pd_q;
  assign err_flag  = errf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s1 <= '0;
      ack_s2 <= '0;
    end else begin
      ack_s1 <= ack_in;
      ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dom_q  <= '0;
      err_q  <= 1'b0;
      cnt    <= '0;
      polls  <= '0;
      clk_q  <= '1;
      iso_q  <= '0;
      rst_q  <= '1;
      pd_q   <= '0;
      errf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          dom_q <= req_dom;
          cnt   <= '0;
          polls <= '0;
          if (!req_ok) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            err_q  <= 1'b0;
            errf_q <= errf_q & ~req_sel;
            if (req_on) begin
              pd_q <= pd_q & ~req_sel;
              st   <= S_ON_ACK;
            end else begin
              clk_q <= clk_q & ~req_sel;
              st    <= S_OFF_ISO;
            end
          end
        end
        S_OFF_ISO: if (settle_end) begin
          iso_q <= iso_q | sel;
          cnt   <= '0;
          st    <= S_OFF_RST;
        end else cnt <= cnt + 1'b1;
        S_OFF_RST: if (settle_end) begin
          rst_q <= rst_q & ~sel;
          cnt   <= '0;
          st    <= S_OFF_PD;
        end else cnt <= cnt + 1'b1;
        S_OFF_PD: if (settle_end) begin
          pd_q <= pd_q | sel;
          cnt  <= '0;
          st   <= S_OFF_ACK;
        end else cnt <= cnt + 1'b1;
        S_OFF_ACK: if (poll_tick) begin
          cnt <= '0;
          if (ack_now) st <= S_DONE;
          else if (polls == PL_W'(OFF_POLLS - 1)) begin
            err_q  <= 1'b1;
            errf_q <= errf_q | sel;
            st     <= S_DONE;
          end else polls <= polls + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_ON_ACK: if (poll_tick) begin
          cnt <= '0;
          if (!ack_now) begin
            rst_q <= rst_q | sel;
            st    <= S_ON_ISO;
          end else if (polls == PL_W'(ON_POLLS - 1)) begin
            err_q  <= 1'b1;
            errf_q <= errf_q | sel;
            st     <= S_DONE;
          end else polls <= polls + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_ON_ISO: if (settle_end) begin
          iso_q <= iso_q & ~sel;
          cnt   <= '0;
          st    <= S_ON_CLK;
        end else cnt <= cnt + 1'b1;
        S_ON_CLK: if (settle_end) begin
          clk_q <= clk_q | sel;
          cnt   <= '0;
          st    <= S_ON_END;
        end else cnt <= cnt + 1'b1;
        S_ON_END: if (settle_end) begin
          cnt <= '0;
          st  <= S_DONE;
        end else cnt <= cnt + 1'b1;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CLK:   rd_data[NUM_DOM-1:0] = clk_q;
      A_RST:   rd_data[NUM_DOM-1:0] = rst_q;
      A_ISO:   rd_data[NUM_DOM-1:0] = iso_q;
      A_PWR:   rd_data[NUM_DOM-1:0] = pd_q;
      A_ACK:   rd_data[NUM_DOM-1:0] = ack_s2;
      default: rd_data = '0;
    endcase
  end

  // R2: reset may only be applied to a domain that is isolated and clock-gated
  p_rst_after_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rst_q & $past(rst_q)) & ~(iso_q & ~clk_q)) == '0);

  // R2: power-down may only be requested for a domain held in reset
  p_pd_after_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_q & ~$past(pd_q)) & ~(iso_q & ~rst_q)) == '0);

  // R4: reset is released only once the switch reports power present
  p_rst_rel_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_q & ~$past(rst_q)) & ($past(ack_s2) | pd_q)) == '0);

  // R4: the clock returns only to a released, de-isolated domain
  p_clk_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_q & ~$past(clk_q)) & (iso_q | ~rst_q | pd_q)) == '0);

  // R7: at most one domain bit moves per vector per cycle
  p_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clk_q ^ $past(clk_q)) && $onehot0(iso_q ^ $past(iso_q)) &&
    $onehot0(rst_q ^ $past(rst_q)) && $onehot0(pd_q ^ $past(pd_q)));

  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a newly set error flag comes with an erroring completion
  p_flag_with_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((errf_q & ~$past(errf_q)) != '0) |-> done_err);

  // R8: a non-gateable index completes at once with an error
  p_bad_dom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_ok) |=> (done && done_err));

endmodule

// File: tb/pwr_gate_seq_test.sv
`timescale 1ns/1ps
module pwr_gate_seq_test;
  localparam int ND = 7;
  localparam int S  = 8;
  localparam int PC = 2;
  localparam int OP = 10;
  localparam int NP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_dom = '0;
  logic req_on = 1'b0;
  logic req_ready, done, done_err;
  logic [ND-1:0] ack_in;
  logic [ND-1:0] clk_en, iso_en, rst_rel, pwr_dn, err_flag;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [ND-1:0] stuck_en = '0, stuck_val = '0, pd_d1, pd_d2;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  pwr_gate_seq #(.NUM_DOM(ND), .IDX_W(3), .GATE_LO(2), .GATE_HI(5), .CLK_MHZ(100),
    .SETTLE_NS(80), .POLL_CYC(PC), .OFF_POLLS(OP), .ON_POLLS(NP), .ADDR_W(8), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dom(req_dom), .req_on(req_on),
    .req_ready(req_ready), .done(done), .done_err(done_err), .ack_in(ack_in),
    .clk_en(clk_en), .iso_en(iso_en), .rst_rel(rst_rel), .pwr_dn(pwr_dn),
    .err_flag(err_flag), .rd_addr(rd_addr), .rd_data(rd_data));

  always @(negedge clk) begin
    if (!rst_n) begin
      pd_d1 <= '0; pd_d2 <= '0; ack_in <= '0;
    end else begin
      pd_d1 <= pwr_dn; pd_d2 <= pd_d1;
      ack_in <= (pd_d2 & ~stuck_en) | (stuck_val & stuck_en);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input int d, input bit on);
    @(negedge clk);
    req_valid = 1'b1; req_dom = 3'(d); req_on = on;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 400) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset();
    chk(clk_en == '1 && rst_rel == '1, "R1 clk/rst", {clk_en, rst_rel}, 32'h3fff);
    chk(iso_en == '0 && pwr_dn == '0 && err_flag == '0, "R1 iso/pd/err", {iso_en, pwr_dn, err_flag}, 0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    rd_addr = 8'h18; #1 chk(rd_data == 32'h7f, "R10 0x18", rd_data, 32'h7f);
    rd_addr = 8'h1C; #1 chk(rd_data == 32'h7f, "R10 0x1C", rd_data, 32'h7f);
    rd_addr = 8'h20; #1 chk(rd_data == 32'h0, "R10 0x20", rd_data, 0);
    rd_addr = 8'h2C; #1 chk(rd_data == 32'h0, "R10 unmapped", rd_data, 0);
  endtask

  task automatic t_off_order(input int d);
    logic [ND-1:0] sc = clk_en, si = iso_en, sr = rst_rel, sp = pwr_dn, m = ND'(1) << d;
    int k = 0, ti = -1, tr = -1, tp = -1;
    send(d, 1'b0);
    chk(clk_en[d] == 1'b0, "R2 clk cleared at accept", 32'(clk_en), 32'(sc & ~m));
    while (!done && k < 400) begin
      @(negedge clk); k++;
      if (k == 2) begin
        chk(req_ready == 1'b0, "R9 busy ready", 32'(req_ready), 0);
        req_valid = 1'b1; req_dom = 3'd4; req_on = 1'b0;
      end
      if (k == 4) req_valid = 1'b0;
      if (ti < 0 && iso_en[d]) ti = k;
      if (tr < 0 && !rst_rel[d]) tr = k;
      if (tp < 0 && pwr_dn[d]) tp = k;
    end
    chk(ti == S, "R2 iso gap", ti, S);
    chk(tr == 2*S, "R2 rst gap", tr, 2*S);
    chk(tp == 3*S, "R2 pd gap", tp, 3*S);
    chk(done && !done_err, "R3 done ok", {done, done_err}, 2);
    chk(((clk_en ^ sc) | (iso_en ^ si) | (rst_rel ^ sr) | (pwr_dn ^ sp)) == m, "R7 only domain bit", 32'((clk_en ^ sc) | (pwr_dn ^ sp)), 32'(m));
    @(negedge clk);
    chk(clk_en[4] && !pwr_dn[4], "R9 busy request dropped", {clk_en[4], pwr_dn[4]}, 2);
    rd_addr = 8'h24; #1 chk(rd_data == 32'(m), "R10 0x24", rd_data, 32'(m));
  endtask

  task automatic t_on_order(input int d);
    int k = 0, tr = -1, ti = -1, tc = -1;
    bit ack_at_r = 1'b1;
    send(d, 1'b1);
    chk(pwr_dn[d] == 1'b0, "R4 pd cleared at accept", 32'(pwr_dn), 0);
    while (!done && k < 400) begin
      @(negedge clk); k++;
      if (tr < 0 && rst_rel[d]) begin tr = k; ack_at_r = ack_in[d]; end
      if (ti < 0 && !iso_en[d]) ti = k;
      if (tc < 0 && clk_en[d]) tc = k;
    end
    chk(tr > 0 && ack_at_r == 1'b0, "R4 ack low before rst release", {tr[15:0], 15'd0, ack_at_r}, 0);
    chk(ti - tr == S, "R4 iso gap", ti - tr, S);
    chk(tc - ti == S, "R4 clk gap", tc - ti, S);
    chk(k - tc == S, "R4 done gap", k - tc, S);
    chk(!done_err && clk_en == '1 && rst_rel == '1 && iso_en == '0 && pwr_dn == '0, "R4 restored",
        {done_err, clk_en, rst_rel, iso_en, pwr_dn}, 32'h3fff << 14);
  endtask

  task automatic t_off_timeout(input int d);
    int k = 0, tp = -1;
    stuck_en[d] = 1'b1; stuck_val[d] = 1'b0;
    send(d, 1'b0);
    while (!done && k < 400) begin
      @(negedge clk); k++;
      if (tp < 0 && pwr_dn[d]) tp = k;
    end
    chk(k - tp == OP*PC, "R5 off timeout window", k - tp, OP*PC);
    chk(done_err && err_flag[d], "R5 error flag", {done_err, err_flag[d]}, 3);
    chk(!clk_en[d] && iso_en[d] && !rst_rel[d] && pwr_dn[d], "R5 bits held",
        {clk_en[d], iso_en[d], rst_rel[d], pwr_dn[d]}, 32'b0101);
    send(d, 1'b1);
    chk(err_flag[d] == 1'b0, "R11 flag cleared at accept", 32'(err_flag), 0);
    wait_done(k);
    chk(done && !done_err && clk_en[d], "R11 recovery ok", {done, done_err, clk_en[d]}, 32'b101);
    stuck_en[d] = 1'b0;
  endtask

  task automatic t_on_timeout(input int d);
    int k;
    stuck_en[d] = 1'b1; stuck_val[d] = 1'b1;
    repeat (4) @(negedge clk);
    rd_addr = 8'h28; #1 chk(rd_data[d] == 1'b1, "R10 0x28 ack", rd_data, 32'(1 << d));
    send(d, 1'b1);
    wait_done(k);
    chk(k == NP*PC, "R6 on timeout window", k, NP*PC);
    chk(done_err && err_flag[d] && rst_rel[d] && !pwr_dn[d], "R6 error flag",
        {done_err, err_flag[d], rst_rel[d], pwr_dn[d]}, 32'b1110);
    stuck_en[d] = 1'b0;
    repeat (5) @(negedge clk);
    send(d, 1'b1);
    wait_done(k);
    chk(!done_err && err_flag[d] == 1'b0, "R11 flag cleared", {done_err, err_flag[d]}, 0);
  endtask

  task automatic t_bad_dom(input int d);
    logic [4*ND-1:0] snap = {clk_en, iso_en, rst_rel, pwr_dn};
    logic [ND-1:0] ef = err_flag;
    send(d, d[0]);
    chk(done && done_err, "R8 immediate error", {done, done_err}, 3);
    chk({clk_en, iso_en, rst_rel, pwr_dn} == snap && err_flag == ef, "R8 no change",
        32'({clk_en, iso_en, rst_rel, pwr_dn}), 32'(snap));
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off_order(3);
    t_on_order(3);
    t_off_order(5);
    t_on_order(5);
    t_off_timeout(2);
    t_on_timeout(4);
    t_bad_dom(0);
    t_bad_dom(1);
    t_bad_dom(6);
    t_bad_dom(7);
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule